// File: doc/BRIEF.md
# Dual-Phase Programmable PWM Actuator Driver

This block produces two digital drive waveforms for a piezo actuator. A prescaler divides the system clock into base time units, and a phase counter runs through a programmed number of those units to form one PWM period. Each output holds its own set of transition times. The output inverts whenever the phase counter enters a unit whose index matches one of its times, so the phase offset between the two outputs is fully programmable. A move runs for a programmed number of whole periods and then stops.

All configuration arrives through a plain write port (strobe, address, data). The port has no back-pressure: a write takes effect on the clock edge where `cfg_wr` is high. When a move starts it captures the period, unit, step count, polarities and one timing set. The timing set depends on the temperature band, when temperature compensation is on, and on the direction bit carried in the start command. Output enables and the idle state stay live. Each output is presented as a drive-enable and a drive-level pair, so an external pad can float, force low or force high.

Top module: `pwmd_actuator`

## Requirements
- R1: Register 0 holds the unit divide factor U. Each base unit of a move lasts U clock cycles, or 1 cycle when U is 0.
- R2: Register 1 holds the period length P in units. The phase counter runs 0..P-1 and wraps, so the pattern of each output repeats every P units and every period starts again from the output's polarity level.
- R3: During phase unit c, an enabled output of a running move drives pol XOR (parity of the number of its transition times t with t <= c). Times at or above P never take effect. Times live at address 8 + band*4 + out*2 + k, with band 0 nominal, 1 hot, 2 cold; out 0 is A, out 1 is B; and k is 0 or 1.
- R4: Register 2 holds the step count S. `busy` rises on the cycle after an accepted start and stays high for exactly S*P*U' cycles, with U' as in R1. It then falls.
- R5: A write to address 4 with bit 0 set is a start. It is ignored while busy, when P is 0 or when S is 0.
- R6: Bit 1 of the start write is the direction. When set, output A uses B's times and B uses A's times, while each output keeps its own polarity.
- R7: Register 3 fields: bit0/bit1 enable A/B, bit2/bit3 polarity A/B, bits 5:4 idle mode, bit6 temperature compensation. An output that is disabled, or any output while not busy, shows the idle mode: 0 or 3 means oe=0 and lvl=0, 1 means oe=1 and lvl=0, 2 means oe=1 and lvl=1. Enable and idle mode act at once, even during a move.
- R8: With compensation on, `temp_band` is sampled at the start: 1 selects hot, 2 selects cold, and 0 or 3 selects nominal. With compensation off, the nominal set is used. A band change during a move has no effect.
- R9: Writes to registers 0 to 2, to the polarity bits or to the timing registers during a move do not alter that move.
- R10: After reset, `busy`, `drv_oe` and `drv_lvl` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_data | input | 8 | Register write data |
| temp_band | input | 2 | Current temperature band code |
| busy | output | 1 | Move in progress |
| drv_oe | output | 2 | Per-output drive enable (bit0 = A) |
| drv_lvl | output | 2 | Per-output drive level (bit0 = A) |

## Verification
Directed moves with known unit, period and time values separate a miscounted prescaler, an off-by-one phase counter and a wrong toggle rule. Moves with swapped direction, each temperature band and compensation off show whether the right timing set reaches the right pin. Writes placed mid-move show which settings are captured and which act live: a repeated start, a changed period, an enable cleared and a band change. Randomized moves with times that often exceed the period, duplicate times, and odd and even toggle counts are compared cycle by cycle against a bench model of the level formula.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;
  localparam int NOUT  = 2;
  localparam int NBAND = 3;

  localparam int ADDR_UNIT = 0;
  localparam int ADDR_PER  = 1;
  localparam int ADDR_STEP = 2;
  localparam int ADDR_CTRL = 3;
  localparam int ADDR_CMD  = 4;
  localparam int ADDR_TIME = 8;

  typedef enum logic [1:0] {
    BAND_NOM  = 2'd0,
    BAND_HOT  = 2'd1,
    BAND_COLD = 2'd2
  } band_e;

  typedef struct packed {
    logic oe;
    logic lvl;
  } pin_t;

  // idle mode: 1 low, 2 high, others float
  function automatic pin_t idle_pin(input logic [1:0] mode);
    pin_t p;
    case (mode)
      2'd1:    p = '{oe: 1'b1, lvl: 1'b0};
      2'd2:    p = '{oe: 1'b1, lvl: 1'b1};
      default: p = '{oe: 1'b0, lvl: 1'b0};
    endcase
    return p;
  endfunction

  function automatic logic [1:0] band_index(input logic comp, input logic [1:0] code);
    if (!comp || code == 2'd3) return BAND_NOM;
    return code;
  endfunction
endpackage

// File: rtl/pwmd_cfg_regs.sv
module pwmd_cfg_regs
  import pwmd_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 5,
  parameter int NTR = 2,
  localparam int NTIME = NBAND * NOUT * NTR
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              data,
  output logic [DW-1:0]              unit_o,
  output logic [DW-1:0]              per_o,
  output logic [DW-1:0]              step_o,
  output logic [NOUT-1:0]            en_o,
  output logic [NOUT-1:0]            pol_o,
  output logic [1:0]                 idle_o,
  output logic                       comp_o,
  output logic [NTIME-1:0][DW-1:0]   tim_o,
  output logic                       start_o,
  output logic                       dir_o
);
  localparam logic [AW-1:0] A_UNIT = AW'(ADDR_UNIT);
  localparam logic [AW-1:0] A_PER  = AW'(ADDR_PER);
  localparam logic [AW-1:0] A_STEP = AW'(ADDR_STEP);
  localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);
  localparam logic [AW-1:0] A_CMD  = AW'(ADDR_CMD);

  logic [6:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_o <= '0;
      per_o  <= '0;
      step_o <= '0;
      ctrl_q <= '0;
    end else if (wr) begin
      if (addr == A_UNIT) unit_o <= data;
      if (addr == A_PER)  per_o  <= data;
      if (addr == A_STEP) step_o <= data;
      if (addr == A_CTRL) ctrl_q <= data[6:0];
    end
  end

  for (genvar i = 0; i < NTIME; i++) begin : g_time
    localparam logic [AW-1:0] A_T = AW'(ADDR_TIME + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 tim_o[i] <= '0;
      else if (wr && addr == A_T) tim_o[i] <= data;
    end
  end

  assign en_o    = ctrl_q[1:0];
  assign pol_o   = ctrl_q[3:2];
  assign idle_o  = ctrl_q[5:4];
  assign comp_o  = ctrl_q[6];
  assign start_o = wr && (addr == A_CMD) && data[0];
  assign dir_o   = data[1];
endmodule

// File: rtl/pwmd_tick.sv
module pwmd_tick #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          load,
  input  logic [DW-1:0] unit,
  output logic          tick
);
  logic [DW-1:0] pre_q;
  logic [DW-1:0] unit_eff;

  assign unit_eff = (unit == '0) ? DW'(1) : unit;
  assign tick     = busy && (pre_q >= unit_eff - DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (load) pre_q <= '0;
    else if (busy) pre_q <= tick ? '0 : pre_q + DW'(1);
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pre_q < unit_eff); // R1
endmodule

// File: rtl/pwmd_chan.sv
module pwmd_chan #(
  parameter int DW  = 8,
  parameter int NTR = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   restart,
  input  logic                   adv,
  input  logic [NTR-1:0][DW-1:0] times_in,
  input  logic                   pol_in,
  input  logic [DW-1:0]          cnt_next,
  output logic                   lvl
);
  logic [NTR-1:0][DW-1:0] times_q;
  logic                   pol_q;

  function automatic logic hit_par(input logic [NTR-1:0][DW-1:0] t, input logic [DW-1:0] v);
    logic p;
    p = 1'b0;
    for (int k = 0; k < NTR; k++) p ^= (t[k] == v);
    return p;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      times_q <= '0;
      pol_q   <= 1'b0;
      lvl     <= 1'b0;
    end else if (load) begin
      times_q <= times_in;
      pol_q   <= pol_in;
      lvl     <= pol_in ^ hit_par(times_in, '0);
    end else if (restart) begin
      lvl <= pol_q ^ hit_par(times_q, '0);
    end else if (adv) begin
      lvl <= lvl ^ hit_par(times_q, cnt_next);
    end
  end

  AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || restart || adv) |=> $stable(lvl)); // R3
endmodule

// File: rtl/pwmd_actuator.sv
module pwmd_actuator
  import pwmd_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 5,
  parameter int NTR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_data,
  input  logic [1:0]       temp_band,
  output logic             busy,
  output logic [NOUT-1:0]  drv_oe,
  output logic [NOUT-1:0]  drv_lvl
);
  localparam int NTIME = NBAND * NOUT * NTR;

  logic [DW-1:0]            unit_r, per_r, step_r;
  logic [NOUT-1:0]          en_r, pol_r;
  logic [1:0]               idle_r;
  logic                     comp_r, start, dir;
  logic [NTIME-1:0][DW-1:0] tim_r;

  pwmd_cfg_regs #(.DW(DW), .AW(AW), .NTR(NTR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .data(cfg_data),
    .unit_o(unit_r), .per_o(per_r), .step_o(step_r), .en_o(en_r), .pol_o(pol_r),
    .idle_o(idle_r), .comp_o(comp_r), .tim_o(tim_r), .start_o(start), .dir_o(dir)
  );

  logic          busy_q, tick, accept;
  logic [DW-1:0] ph_q, step_q, per_l, step_l, unit_l, ph_next;
  logic          last_ph, last_step, restart, adv, done;

  assign accept    = start && !busy_q && (per_r != '0) && (step_r != '0);
  assign last_ph   = ph_q == per_l - DW'(1);
  assign last_step = step_q == step_l - DW'(1);
  assign restart   = tick && last_ph && !last_step;
  assign adv       = tick && !last_ph;
  assign done      = tick && last_ph && last_step;
  assign ph_next   = ph_q + DW'(1);

  pwmd_tick #(.DW(DW)) u_tick (
    .clk(clk), .rst_n(rst_n), .busy(busy_q), .load(accept), .unit(unit_l), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      step_q <= '0;
      per_l  <= '0;
      step_l <= '0;
      unit_l <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      ph_q   <= '0;
      step_q <= '0;
      per_l  <= per_r;
      step_l <= step_r;
      unit_l <= unit_r;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
      end else if (restart) begin
        ph_q   <= '0;
        step_q <= step_q + DW'(1);
      end else if (adv) begin
        ph_q <= ph_next;
      end
    end
  end

  // timing set selection: band, then direction swap
  logic [1:0]                       bidx;
  logic [NOUT-1:0][NTR-1:0][DW-1:0] sel_times;
  assign bidx = band_index(comp_r, temp_band);

  always_comb begin
    for (int o = 0; o < NOUT; o++) begin
      for (int k = 0; k < NTR; k++) begin
        int src;
        src = dir ? (NOUT - 1 - o) : o;
        sel_times[o][k] = tim_r[(int'(bidx) * NOUT + src) * NTR + k];
      end
    end
  end

  logic [NOUT-1:0] lvl;
  for (genvar o = 0; o < NOUT; o++) begin : g_ch
    pwmd_chan #(.DW(DW), .NTR(NTR)) u_chan (
      .clk(clk), .rst_n(rst_n), .load(accept), .restart(restart), .adv(adv),
      .times_in(sel_times[o]), .pol_in(pol_r[o]), .cnt_next(ph_next), .lvl(lvl[o])
    );
  end

  pin_t ip;
  always_comb begin
    ip = idle_pin(idle_r);
    for (int o = 0; o < NOUT; o++) begin
      if (busy_q && en_r[o]) begin
        drv_oe[o]  = 1'b1;
        drv_lvl[o] = lvl[o];
      end else begin
        drv_oe[o]  = ip.oe;
        drv_lvl[o] = ip.lvl;
      end
    end
  end

  assign busy = busy_q;

  AST_PH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ph_q < per_l); // R2
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> step_q < step_l); // R4
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(tick)); // R4
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start)); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(per_l) && $stable(step_l) && $stable(unit_l))); // R9
endmodule

// File: tb/pwmd_actuator_bench.sv
module pwmd_actuator_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic [1:0] temp_band = '0;
  logic       busy;
  logic [1:0] drv_oe, drv_lvl;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwmd_actuator u_pwmd_actuator (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .temp_band(temp_band), .busy(busy), .drv_oe(drv_oe), .drv_lvl(drv_lvl)
  );

  // shadow of the register file
  int sh_unit, sh_per, sh_step, sh_en, sh_pol, sh_idle, sh_comp;
  int sh_tim[12];
  // values captured by the running move
  int mv_unit, mv_per, mv_step, mv_pol;
  int mv_tim[2][2];

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void sh_apply(int a, int d);
    case (a)
      0: sh_unit = d;
      1: sh_per  = d;
      2: sh_step = d;
      3: begin
        sh_en = d & 3; sh_pol = (d >> 2) & 3; sh_idle = (d >> 4) & 3; sh_comp = (d >> 6) & 1;
      end
      default: if (a >= 8 && a < 20) sh_tim[a-8] = d;
    endcase
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 5'(a); cfg_data = 8'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
    sh_apply(a, d);
  endtask

  function automatic int exp_level(int o, int k);
    int u, c, n;
    u = (mv_unit == 0) ? 1 : mv_unit;
    c = (k / u) % mv_per;
    n = 0;
    for (int j = 0; j < 2; j++) if (mv_tim[o][j] <= c) n++;
    return ((mv_pol >> o) & 1) ^ (n & 1);
  endfunction

  task automatic chk_pins(string req, bit bsy, int k);
    for (int o = 0; o < 2; o++) begin
      int eoe, elv;
      if (bsy && ((sh_en >> o) & 1)) begin
        eoe = 1; elv = exp_level(o, k);
      end else begin
        eoe = (sh_idle == 1 || sh_idle == 2) ? 1 : 0;
        elv = (sh_idle == 2) ? 1 : 0;
      end
      chk(req, {31'd0, drv_oe[o]}, eoe);
      chk(req, {31'd0, drv_lvl[o]}, elv);
    end
  endtask

  // start a move; optional write at cycle mid_k of the move
  task automatic run_move(string req, int dir, int band, int mid_k, int mid_a, int mid_d);
    bit acc;
    int n, b;
    temp_band = 2'(band);
    acc = (sh_per != 0) && (sh_step != 0);
    if (acc) begin
      mv_unit = sh_unit; mv_per = sh_per; mv_step = sh_step; mv_pol = sh_pol;
      b = (sh_comp == 0 || band == 3) ? 0 : band;
      for (int o = 0; o < 2; o++)
        for (int j = 0; j < 2; j++)
          mv_tim[o][j] = sh_tim[b*4 + (dir ? 1 - o : o)*2 + j];
    end
    wr(4, (dir << 1) | 1);
    if (!acc) begin
      for (int i = 0; i < 3; i++) begin
        chk("R5", {31'd0, busy}, 0);
        chk_pins("R5", 0, 0);
        @(negedge clk);
      end
      return;
    end
    n = ((mv_unit == 0) ? 1 : mv_unit) * mv_per * mv_step;
    for (int k = 0; k < n; k++) begin
      chk("R4", {31'd0, busy}, 1);
      chk_pins(req, 1, k);
      if (k == mid_k) begin
        cfg_wr = 1'b1; cfg_addr = 5'(mid_a); cfg_data = 8'(mid_d);
        temp_band = ~temp_band;
        sh_apply(mid_a, mid_d);
      end
      @(negedge clk);
      cfg_wr = 1'b0;
    end
    chk("R4", {31'd0, busy}, 0);
    chk_pins("R7", 0, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    sh_unit = 0; sh_per = 0; sh_step = 0; sh_en = 0; sh_pol = 0; sh_idle = 0; sh_comp = 0;
    for (int i = 0; i < 12; i++) sh_tim[i] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {31'd0, busy}, 0);
    chk("R10", {30'd0, drv_oe}, 0);
    chk("R10", {30'd0, drv_lvl}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: period 0 and step 0 starts are ignored
    wr(0, 2); wr(2, 2);
    wr(3, 8'h13);
    run_move("R5", 0, 0, -1, 0, 0);
    wr(1, 6); wr(2, 0);
    run_move("R5", 0, 0, -1, 0, 0);
    wr(2, 2);

    // R3 basic: A times {1,3}, B times {4,9 beyond period}, pol B=1, idle low
    wr(8, 1); wr(9, 3); wr(10, 4); wr(11, 9);
    wr(3, 8'h1B);
    run_move("R3", 0, 0, -1, 0, 0);
    // R3 duplicate times cancel, time 0 toggles at period start
    wr(8, 0); wr(9, 2); wr(10, 5); wr(11, 5);
    run_move("R3", 0, 0, -1, 0, 0);

    // R1 unit variants
    wr(0, 3); run_move("R1", 0, 0, -1, 0, 0);
    wr(0, 0); run_move("R1", 0, 0, -1, 0, 0);

    // R2 wrap with multiple periods
    wr(1, 4); wr(2, 3); wr(0, 1);
    run_move("R2", 0, 0, -1, 0, 0);

    // R6 direction swap
    wr(8, 1); wr(9, 2); wr(10, 3); wr(11, 15);
    run_move("R6", 1, 0, -1, 0, 0);

    // R8 bands: hot set 12..15, cold set 16..19
    wr(12, 0); wr(13, 3); wr(14, 2); wr(15, 2);
    wr(16, 1); wr(17, 1); wr(18, 0); wr(19, 1);
    wr(3, 8'h5B);
    run_move("R8", 0, 1, 5, 0, 1);
    run_move("R8", 0, 2, 3, 0, 1);
    run_move("R8", 1, 3, -1, 0, 0);
    wr(3, 8'h1B);
    run_move("R8", 0, 2, -1, 0, 0);

    // R5 restart while busy, R9 mid-move changes
    run_move("R5", 0, 0, 4, 4, 3);
    run_move("R9", 0, 0, 2, 1, 9);
    run_move("R9", 0, 0, 3, 9, 0);
    run_move("R9", 0, 0, 1, 3, 8'h1F);
    // R7 enable cleared and idle high mid-move
    run_move("R7", 0, 0, 6, 3, 8'h2A);

    // randomized moves
    for (int r = 0; r < 25; r++) begin
      int mk;
      wr(0, $urandom_range(0, 3));
      wr(1, $urandom_range(1, 10));
      wr(2, $urandom_range(1, 3));
      wr(3, $urandom_range(0, 127));
      for (int a = 8; a < 20; a++) wr(a, $urandom_range(0, 12));
      mk = $urandom_range(0, 10);
      run_move("R2", $urandom_range(0, 1), $urandom_range(0, 3),
               mk, $urandom_range(0, 19), $urandom_range(0, 255));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule